// File: doc/BRIEF.md
# Trigger-Armed Alternating Source Selector

This block drives a pair of complementary select lines that steer a shared output between two upstream data sources, taking each in turn. It runs from a clock at four times the per-source sampling rate, so one full select cycle (source 1, then source 2) lasts four clocks. Each clock is one quarter of that cycle.

Until it is armed, both selects stay low. It is armed by the serial pattern one, zero, one on the trigger input over three consecutive clock edges. After that the selects alternate without stopping, at a fixed latency from the pattern. The same pattern seen again later re-aligns the cycle.

Two strap inputs are pulled high by default. They move the select window by a quarter of a cycle (centre sampling) and by a half cycle (swapped sources). The straps are captured only when the pattern is recognised. Every state flop is held as three copies resolved by a 2-of-3 vote, so one upset copy cannot disturb the outputs.

Top module: `mux_select_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to the unarmed state after that edge: `s1`, `s2` and `armed` are all 0.
- R2: While unarmed, `s1` and `s2` both stay 0 for any trigger sequence that does not contain 1, 0, 1 on consecutive edges.
- R3: The trigger values 1, 0, 1 sampled on three consecutive rising edges arm the block: `armed` is 1 after the next rising edge.
- R4: With both straps high, `s1`=1 and `s2`=0 after the fourth rising edge that follows the edge sampling the first 1 of the pattern. After the third such edge, `s2`=1 for one clock.
- R5: Once armed, exactly one of `s1`/`s2` is high in every cycle. Each stays high for two clocks, and the two alternate with a period of four clocks.
- R6: With `phase` and `mode` both high, the source-1 window starts at that fourth edge, so sampling falls in the second half of each source's slot.
- R7: `phase` low at arming shifts the cycle by two clocks, so after the fourth edge `s2`=1 and `s1`=0, and the sources swap slots.
- R8: `mode` low at arming advances the cycle by one clock, so `s1` rises one clock earlier than in R6 (right after the third edge) and holds for two clocks.
- R9: Both straps low at arming apply the one-clock advance and the two-clock shift together.
- R10: Strap changes after arming have no effect on `s1`/`s2` until the pattern is seen again.
- R11: A new 1, 0, 1 pattern while armed re-aligns the cycle with the same latency as R4, using the straps sampled at that moment.
- R12: A single corrupted copy in any triplicated register leaves `s1`, `s2` and `armed` unchanged, and that copy is rewritten from the voted value at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, four times the per-source sampling rate |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | 1 | Serial trigger; 1,0,1 arms/re-aligns |
| phase | input | 1 | Strap, high by default; low swaps source slots |
| mode | input | 1 | Strap, high by default; low advances by one quarter |
| s1 | output | 1 | Select source 1 |
| s2 | output | 1 | Select source 2 |
| armed | output | 1 | High once the trigger pattern has been seen |

## Verification
A wrong phase count or a wrong captured strap offset shows at once as a slot misplaced by one or more clocks. Because the period is only four clocks, every such error reaches the selects within four clocks of arming. A lost or false pattern hit shows as `armed` and the selects going wrong one clock after the third trigger bit. Single-copy corruptions are injected into the counter, offset, arming and trigger-history registers, and the outputs are compared on every clock before and after each injection. A broken voter therefore shows up in the same clock as the upset.

// File: rtl/mux_seq_pkg.sv
// Shared constants and helpers for the alternating source selector.
// Assumes a four-quarter select cycle with two quarters per source.
package mux_seq_pkg;
    localparam int PHASE_W   = 2;
    localparam int HIST_W    = 3;
    localparam logic [HIST_W-1:0]  ARM_PATTERN = 3'b101;
    // Count loaded on arming so source 1 is selected four edges after the first 1.
    localparam logic [PHASE_W-1:0] LOAD_COUNT  = 2'd1;

    // Quarter offset from the straps: mode low adds one, phase low adds two.
    function automatic logic [PHASE_W-1:0] strap_offset(input logic phase_pin,
                                                        input logic mode_pin);
        return {~phase_pin, ~mode_pin};
    endfunction
endpackage

// File: rtl/tmr_reg.sv
// Triplicated register with 2-of-3 majority vote.
// Each copy reloads from the common next value, so a single upset copy is
// scrubbed at the next edge. Synchronous active-low reset to RST_VAL.
module tmr_reg #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] q_a, q_b, q_c;

    // Copy A storage.
    always_ff @(posedge clk) begin
        if (!rst_n) q_a <= RST_VAL;
        else        q_a <= d;
    end

    // Copy B storage.
    always_ff @(posedge clk) begin
        if (!rst_n) q_b <= RST_VAL;
        else        q_b <= d;
    end

    // Copy C storage.
    always_ff @(posedge clk) begin
        if (!rst_n) q_c <= RST_VAL;
        else        q_c <= d;
    end

    // Bitwise majority of the three copies.
    always_comb q = (q_a & q_b) | (q_a & q_c) | (q_b & q_c);

    // R12: voted value follows any two agreeing copies.
    always_comb begin
        if (q_a == q_b) p_vote_pair_r12: assert (q == q_a);
    end
endmodule

// File: rtl/trig_pattern_det.sv
// Shifts the serial trigger into a triplicated history and flags when the
// last three samples form the arming pattern. Assumes trig is synchronous.
module trig_pattern_det
    import mux_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic hit
);
    logic [HIST_W-1:0] hist_q, hist_d;

    // Next history: oldest sample drops off, newest enters at bit 0.
    always_comb hist_d = {hist_q[HIST_W-2:0], trig};

    tmr_reg #(.W(HIST_W), .RST_VAL('0)) u_hist (
        .clk(clk), .rst_n(rst_n), .d(hist_d), .q(hist_q)
    );

    // Pattern match on the stored samples.
    always_comb hit = (hist_q == ARM_PATTERN);

    // R3: history shifts one sample per edge.
    p_hist_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));
endmodule

// File: rtl/select_phase_gen.sv
// Quarter-cycle counter with strap offset and select decode.
// On load the counter restarts at LOAD_COUNT and the straps are captured;
// otherwise an armed counter advances by one each clock. All state is TMR.
module select_phase_gen
    import mux_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic phase,
    input  logic mode,
    output logic sel1,
    output logic sel2,
    output logic armed
);
    logic [PHASE_W-1:0] cnt_q, cnt_d, off_q, off_d, slot;
    logic [0:0]         arm_q, arm_d;

    // Next-state: restart on load, free-run when armed, else hold.
    always_comb begin
        cnt_d = cnt_q;
        off_d = off_q;
        arm_d = arm_q;
        if (load) begin
            cnt_d = LOAD_COUNT;
            off_d = strap_offset(phase, mode);
            arm_d = 1'b1;
        end else if (arm_q[0]) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    tmr_reg #(.W(PHASE_W), .RST_VAL('0)) u_cnt (
        .clk(clk), .rst_n(rst_n), .d(cnt_d), .q(cnt_q)
    );
    tmr_reg #(.W(PHASE_W), .RST_VAL('0)) u_off (
        .clk(clk), .rst_n(rst_n), .d(off_d), .q(off_q)
    );
    tmr_reg #(.W(1), .RST_VAL('0)) u_arm (
        .clk(clk), .rst_n(rst_n), .d(arm_d), .q(arm_q)
    );

    // Decode: upper half of the offset slot is source 1.
    always_comb begin
        slot  = cnt_q + off_q;
        armed = arm_q[0];
        sel1  = armed &  slot[PHASE_W-1];
        sel2  = armed & ~slot[PHASE_W-1];
    end

    // R2: no select while unarmed.
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (!sel1 && !sel2));
    // R5: selects never overlap.
    p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel1 && sel2));
    // R5: free-running count steps by one between loads.
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(armed) && !$past(load)) |->
            cnt_q == PHASE_W'($past(cnt_q) + 1'b1));
    // R10: captured straps hold between loads.
    p_straps_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load)) |-> $stable(off_q));
endmodule

// File: rtl/mux_select_seq.sv
// Top of the alternating source selector: pattern detector arms the
// phase generator, which drives the two complementary selects.
// Assumes straps are static after arming and trig is clock-synchronous.
module mux_select_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic phase,
    input  logic mode,
    output logic s1,
    output logic s2,
    output logic armed
);
    logic hit;

    trig_pattern_det u_det (
        .clk(clk), .rst_n(rst_n), .trig(trig), .hit(hit)
    );

    select_phase_gen u_phase (
        .clk(clk), .rst_n(rst_n), .load(hit), .phase(phase), .mode(mode),
        .sel1(s1), .sel2(s2), .armed(armed)
    );

    // R4: default straps give source 1 two edges after the load edge.
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && phase && mode) |=> ##1 (s1 && !s2));
    // R3: a pattern hit leaves the block armed.
    p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> armed);
endmodule

// File: tb/mux_select_seq_test.sv
module mux_select_seq_test;
    typedef struct {
        logic  s1;
        logic  s2;
        logic  armed;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0;
    logic phase = 1'b1;
    logic mode = 1'b1;
    logic s1, s2, armed;

    int   n_run = 0;
    int   n_fail = 0;
    exp_t sb_q[$];
    string cur_tag = "R1";

    // Bench reference state built from the requirements.
    logic [2:0] m_hist = '0;
    logic [1:0] m_cnt = '0;
    logic [1:0] m_off = '0;
    logic       m_arm = 1'b0;

    always #2.5 clk = ~clk;

    mux_select_seq uut (
        .clk(clk), .rst_n(rst_n), .trig(trig), .phase(phase), .mode(mode),
        .s1(s1), .s2(s2), .armed(armed)
    );

    // Monitor: compare each clock's outputs with the queued expectation.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_run++;
            if (s1 !== e.s1 || s2 !== e.s2 || armed !== e.armed) begin
                n_fail++;
                $display("FAIL %s: s1/s2/armed = %b%b%b expected %b%b%b at %0t",
                         e.tag, s1, s2, armed, e.s1, e.s2, e.armed, $time);
            end
        end
    end

    // Driver: apply one clock of stimulus and push the expected outputs.
    task automatic cyc(input logic t, input logic r);
        logic [1:0] p;
        exp_t e;
        trig  = t;
        rst_n = r;
        @(posedge clk);
        if (!r) begin
            m_hist = '0; m_cnt = '0; m_off = '0; m_arm = 1'b0;
        end else begin
            if (m_hist == 3'b101) begin
                m_cnt = 2'd1;
                m_off = {~phase, ~mode};
                m_arm = 1'b1;
            end else if (m_arm) begin
                m_cnt = m_cnt + 2'd1;
            end
            m_hist = {m_hist[1:0], t};
        end
        p = m_cnt + m_off;
        e.s1 = m_arm & p[1];
        e.s2 = m_arm & ~p[1];
        e.armed = m_arm;
        e.tag = cur_tag;
        sb_q.push_back(e);
        @(negedge clk);
        #0.1;
    endtask

    // Direct check of the outputs at this moment.
    task automatic chk(input string tag, input logic e1, input logic e2);
        n_run++;
        if (s1 !== e1 || s2 !== e2) begin
            n_fail++;
            $display("FAIL %s: s1/s2 = %b%b expected %b%b", tag, s1, s2, e1, e2);
        end
    endtask

    task automatic arm_seq();
        cyc(1, 1); cyc(0, 1); cyc(1, 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 1);
    endtask

    // Watchdog.
    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state.
        cur_tag = "R1";
        cyc(0, 0); cyc(0, 0);
        // R2: non-matching trigger sequence keeps block unarmed.
        cur_tag = "R2";
        cyc(1, 1); cyc(1, 1); cyc(0, 1); cyc(0, 1); cyc(1, 1); cyc(1, 1); cyc(0, 1); cyc(0, 1);
        // R3/R4/R6: default straps, exact latency.
        cur_tag = "R4";
        arm_seq(); cyc(0, 1);
        chk("R4 third edge", 1'b0, 1'b1);
        cyc(0, 1);
        chk("R4 fourth edge", 1'b1, 1'b0);
        cur_tag = "R5";
        idle(12);
        // R10: strap changes after arming have no effect.
        cur_tag = "R10";
        phase = 1'b0; mode = 1'b0;
        idle(8);
        // R7: phase low.
        cur_tag = "R1"; cyc(0, 0);
        cur_tag = "R7"; phase = 1'b0; mode = 1'b1;
        arm_seq(); idle(2);
        chk("R7 fourth edge", 1'b0, 1'b1);
        idle(6);
        // R8: mode low.
        cur_tag = "R1"; cyc(0, 0);
        cur_tag = "R8"; phase = 1'b1; mode = 1'b0;
        arm_seq(); cyc(0, 1);
        chk("R8 third edge", 1'b1, 1'b0);
        idle(7);
        // R9: both low.
        cur_tag = "R1"; cyc(0, 0);
        cur_tag = "R9"; phase = 1'b0; mode = 1'b0;
        arm_seq(); idle(8);
        // R11: re-trigger while armed with new straps.
        cur_tag = "R11"; phase = 1'b1; mode = 1'b1;
        idle(1); arm_seq(); idle(2);
        chk("R11 realign", 1'b1, 1'b0);
        idle(6);
        // R12: single-copy upsets in each triplicated register.
        cur_tag = "R12";
        force uut.u_phase.u_cnt.q_b = 2'b11;
        idle(3);
        release uut.u_phase.u_cnt.q_b;
        idle(2);
        force uut.u_phase.u_off.q_c = 2'b10;
        idle(3);
        release uut.u_phase.u_off.q_c;
        idle(2);
        force uut.u_phase.u_arm.q_a = 1'b0;
        idle(3);
        release uut.u_phase.u_arm.q_a;
        idle(2);
        force uut.u_det.u_hist.q_b = 3'b101;
        idle(3);
        release uut.u_det.u_hist.q_b;
        idle(4);
        // R1: reset while armed returns to unarmed.
        cur_tag = "R1";
        cyc(0, 0); idle(3);
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule